// File: doc/BRIEF.md
# Wired Interrupt to Message Converter

The block turns a bank of wired interrupt lines into message-signalled interrupt requests. Every line is resynchronised, watched for a rising edge or an active-high level according to its own trigger bit, and, when it needs service, queued as pending. A fixed-priority arbiter takes the lowest pending line. Its message goes out on a single valid/ready channel and stays there until the receiver accepts it. Each message carries a device identifier and the event identifier that software programmed for that line.

Lines are grouped in nodes of 128. Line `irq_i[k]` is global interrupt number 64 + k, so global numbers 0 to 63 are never produced. Node n (counting from 1) has a 4 KiB register window at byte address n × 0x1000. The window holds the trigger words at offsets 0x000 to 0x00C and the per-line vector words from offset 0x200 upward. A separate status/clear region at 0xA000 is indexed by global interrupt number, not by position within a node. A level-triggered line sets its status bit when its message is accepted and stays silent until software clears that bit.

Top module: `wire_msi_bridge`

## Requirements
- R1: After reset, msg_valid_o is low, every trigger bit is 0 (rising edge), every event field is 0, and every status bit is 0.
- R2: The vector word of local line i is at node_base + 0x200 + 4·i. It reads as bits [11:0] = DEV_ID, bits [21:12] = event field, and bits [31:22] = 0. A write updates only bits [21:12].
- R3: The trigger word at node_base + 4·(i/32), bit i%32, selects the trigger type of local line i: 1 = active-high level, 0 = rising edge. The word reads back as written.
- R4: Reads from unmapped addresses return 0 and writes to them change nothing. Unmapped addresses include node window 0, windows above NUM_NODES, unused offsets inside a window, and the status words for global numbers 0 to 63 (0xA000, 0xA004).
- R5: An edge line produces exactly one message for each 0-to-1 transition of its synchronised input. Holding the input high produces no further message.
- R6: A level line produces a message while its input is high and its status bit is 0. Acceptance of that message sets the status bit, and no further message follows until the bit is cleared. If the input is still high after the clear, a new message follows.
- R7: The status word at 0xA000 + 4·(g/32), bit g%32, belongs to global number g. It reads back status. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: When several lines are pending, the lowest-numbered line is sent first.
- R9: While msg_valid_o is high and msg_ready_i is low, msg_valid_o, msg_dev_id_o and msg_event_id_o hold their values. After an accepted message, msg_valid_o is low for one cycle.
- R10: A message carries DEV_ID on msg_dev_id_o and, on msg_event_id_o, the event field of the chosen line as it was when the message was launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 128·NUM_NODES | Wired interrupt lines; bit k is global number 64+k |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| msg_valid_o | output | 1 | Message present |
| msg_ready_i | input | 1 | Receiver accepts message |
| msg_dev_id_o | output | 12 | Device identifier of the message |
| msg_event_id_o | output | 10 | Event identifier of the message |

## Verification
The bench targets the split in indexing. The same line is reached at its node-relative offset for vector and trigger, and at its global offset for status. A design that reused one index for both would clear the wrong bit, or find no bit at all, and a level line would never speak again. It also checks that a level line stays silent with its input still high and that a zero write to the clear word does not release it. It checks that the words for the reserved numbers 0 to 63 ignore writes, that two lines raised together come out lowest first, and that a stalled message does not change. A design that dropped pending on launch instead of on acceptance, or that treated a held edge input as a level, would send extra or missing messages here.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  localparam int PINS_PER_NODE = 128;
  localparam int RSVD_PINS     = 64;
  localparam int WORD_W        = 32;
  localparam int WORDS_PER_NODE = PINS_PER_NODE / WORD_W;
  localparam int EVT_W         = 10;
  localparam int DEV_W         = 12;
  localparam int ADDR_W        = 16;
  localparam logic [3:0] CLR_PAGE = 4'hA;
  localparam logic [2:0] VEC_PAGE = 3'b001;   // offset 0x200..0x3FC
endpackage

// File: rtl/wmb_sync.sv
module wmb_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end
  assign q_o = s1_q;
endmodule

// File: rtl/wmb_prio_enc.sv
module wmb_prio_enc #(
  parameter int N  = 128,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign found_o = |req_i;
endmodule

// File: rtl/wmb_regs.sv
module wmb_regs
  import wmb_pkg::*;
#(
  parameter int              NUM_NODES = 1,   // at most 9: window 10 is the clear page
  parameter logic [DEV_W-1:0] DEV_ID   = 12'h5A3,
  localparam int NPINS = NUM_NODES * PINS_PER_NODE,
  localparam int PIN_W = $clog2(NPINS),
  localparam int NTW   = NUM_NODES * WORDS_PER_NODE,
  localparam int TW_W  = $clog2(NTW)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [WORD_W-1:0]           wdata_i,
  output logic [WORD_W-1:0]           rdata_o,
  input  logic [NPINS-1:0]            set_stat_i,
  output logic [NPINS-1:0]            lvl_o,
  output logic [NPINS-1:0]            stat_o,
  output logic [NPINS-1:0][EVT_W-1:0] evt_o
);
  logic [NTW-1:0][WORD_W-1:0] type_q, stat_q;
  logic [NPINS-1:0][EVT_W-1:0] evt_q;

  logic [3:0]  node;
  logic [11:0] off;
  logic [9:0]  cw;
  logic        node_ok, is_type, is_vec, is_clr;
  logic [TW_W-1:0]  tword, sword;
  logic [PIN_W-1:0] loc;

  always_comb begin
    node    = addr_i[15:12];
    off     = addr_i[11:0];
    cw      = addr_i[11:2];
    node_ok = (node != 4'd0) && (int'(node) <= NUM_NODES);
    is_type = node_ok && (off[11:4] == 8'd0);
    is_vec  = node_ok && (off[11:9] == VEC_PAGE);
    // global word g/32; words 0 and 1 cover reserved numbers
    is_clr  = (node == CLR_PAGE) && (int'(cw) >= 2) && (int'(cw) < 2 + NTW);
    tword   = TW_W'((int'(node) - 1) * WORDS_PER_NODE + int'(off[3:2]));
    loc     = PIN_W'((int'(node) - 1) * PINS_PER_NODE + int'(off[8:2]));
    sword   = TW_W'(int'(cw) - 2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
      evt_q  <= '0;
    end else if (wr_i) begin
      if (is_type) type_q[tword] <= wdata_i;
      if (is_vec)  evt_q[loc]    <= wdata_i[DEV_W +: EVT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else begin
      for (int w = 0; w < NTW; w++) begin
        logic [WORD_W-1:0] clr;
        clr = (wr_i && is_clr && (sword == TW_W'(w))) ? wdata_i : '0;
        // a fresh acceptance wins over a simultaneous clear
        stat_q[w] <= (stat_q[w] & ~clr) | set_stat_i[w*WORD_W +: WORD_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_type)     rdata_o = type_q[tword];
    else if (is_vec) rdata_o = {{(WORD_W-EVT_W-DEV_W){1'b0}}, evt_q[loc], DEV_ID};
    else if (is_clr) rdata_o = stat_q[sword];
  end

  assign lvl_o  = type_q;
  assign stat_o = stat_q;
  assign evt_o  = evt_q;
endmodule

// File: rtl/wire_msi_bridge.sv
module wire_msi_bridge
  import wmb_pkg::*;
#(
  parameter int               NUM_NODES = 1,
  parameter logic [11:0]      DEV_ID    = 12'h5A3,
  localparam int NPINS = NUM_NODES * PINS_PER_NODE,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  irq_i,
  input  logic              reg_wr_i,
  input  logic [15:0]       reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [11:0]       msg_dev_id_o,
  output logic [9:0]        msg_event_id_o
);
  logic [NPINS-1:0] irq_s, irq_d, rise, lvl, stat, edge_pend, req, acc_oh, set_stat;
  logic [NPINS-1:0][EVT_W-1:0] evt;
  logic             found, accept;
  logic [PIN_W-1:0] idx, sel_q;

  wmb_sync #(.W(NPINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_i), .q_o(irq_s)
  );

  wmb_regs #(.NUM_NODES(NUM_NODES), .DEV_ID(DEV_ID)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .set_stat_i(set_stat), .lvl_o(lvl), .stat_o(stat), .evt_o(evt)
  );

  assign accept   = msg_valid_o && msg_ready_i;
  assign acc_oh   = accept ? (NPINS'(1) << sel_q) : '0;
  assign set_stat = acc_oh & lvl;
  assign rise     = irq_s & ~irq_d;
  assign req      = (edge_pend & ~lvl) | (lvl & irq_s & ~stat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_d     <= '0;
      edge_pend <= '0;
    end else begin
      irq_d     <= irq_s;
      edge_pend <= (edge_pend & ~acc_oh) | (rise & ~lvl);
    end
  end

  wmb_prio_enc #(.N(NPINS)) u_enc (
    .req_i(req), .found_o(found), .idx_o(idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o    <= 1'b0;
      sel_q          <= '0;
      msg_event_id_o <= '0;
    end else if (accept) begin
      msg_valid_o <= 1'b0;
    end else if (!msg_valid_o && found) begin
      msg_valid_o    <= 1'b1;
      sel_q          <= idx;
      msg_event_id_o <= evt[idx];
    end
  end

  assign msg_dev_id_o = DEV_ID;
endmodule

// File: rtl/wmb_chk.sv
module wmb_chk #(
  parameter logic [11:0] DEV_ID = 12'h5A3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] reg_addr_i,
  input logic [31:0] reg_rdata_o,
  input logic        msg_valid_o,
  input logic        msg_ready_i,
  input logic [9:0]  msg_event_id_o
);
  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_event_id_o));
  // R9
  accept_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_ready_i |=> !msg_valid_o);
  // R2
  vec_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[15:12] == 4'd1 && reg_addr_i[11:9] == 3'b001)
      |-> (reg_rdata_o[11:0] == DEV_ID && reg_rdata_o[31:22] == 10'd0));
  // R4
  node0_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[15:12] == 4'd0) |-> reg_rdata_o == 32'd0);
  // R4
  rsvd_clr_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[15:12] == 4'hA && reg_addr_i[11:3] == 9'd0) |-> reg_rdata_o == 32'd0);
endmodule

bind wire_msi_bridge wmb_chk #(.DEV_ID(DEV_ID)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i), .msg_event_id_o(msg_event_id_o)
);

// File: tb/wire_msi_bridge_tb.sv
module wire_msi_bridge_tb;
  localparam int NPINS = 128;
  localparam logic [11:0] DEV = 12'h5A3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [NPINS-1:0] irq = '0;
  logic        wr = 1'b0, ready = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        valid;
  logic [11:0] dev;
  logic [9:0]  evt;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wire_msi_bridge #(.NUM_NODES(1), .DEV_ID(DEV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .msg_valid_o(valid), .msg_ready_i(ready),
    .msg_dev_id_o(dev), .msg_event_id_o(evt)
  );

  // {local pin, event}, all rising-edge lines
  localparam logic [16:0] VEC [5] = '{
    {7'd0,   10'h011}, {7'd17,  10'h2A5}, {7'd64, 10'h3FF},
    {7'd127, 10'h100}, {7'd96,  10'h07C}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = '0;
  endtask

  task automatic reg_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata; addr = '0;
  endtask

  function automatic logic [15:0] vec_a(input int p); return 16'(32'h1200 + 4 * p); endfunction

  task automatic take_msg(input logic [9:0] exp, input string req);
    bit seen = 0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (valid) seen = 1;
    end
    chk(seen, req, {31'd0, valid}, 32'd1);
    if (seen) begin
      chk(evt == exp && dev == DEV, req, {10'd0, evt, dev}, {10'd0, exp, DEV});
      ready = 1'b1;
      @(negedge clk); ready = 1'b0;
    end
  endtask

  task automatic quiet(input int n, input string req);
    bit any = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (valid) any = 1;
    end
    chk(!any, req, {31'd0, any}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(!valid, "R1", {31'd0, valid}, 32'd0);
    reg_rd(16'h1000, d); chk(d == 0, "R1 type", d, 0);
    reg_rd(vec_a(5), d); chk(d == {20'd0, DEV}, "R1 vector", d, {20'd0, DEV});
    reg_rd(16'hA008, d); chk(d == 0, "R1 status", d, 0);

    // R2 vector write touches only event field
    reg_wr(vec_a(9), 32'hFFFF_FFFF);
    reg_rd(vec_a(9), d); chk(d == {10'd0, 10'h3FF, DEV}, "R2", d, {10'd0, 10'h3FF, DEV});

    // R3 trigger mapping: local pin 40 -> word 1 bit 8
    reg_wr(16'h1004, 32'h0000_0100);
    reg_rd(16'h1004, d); chk(d == 32'h100, "R3", d, 32'h100);
    reg_wr(16'h1004, 32'h0);

    // R4 unmapped space
    reg_wr(16'h0200, 32'hDEAD_BEEF);
    reg_rd(16'h0200, d); chk(d == 0, "R4 node0", d, 0);
    reg_rd(16'h2200, d); chk(d == 0, "R4 node2", d, 0);
    reg_rd(16'h1100, d); chk(d == 0, "R4 hole", d, 0);

    // R5 / R10 table: one message per edge, none while held
    foreach (VEC[k]) begin
      int p = int'(VEC[k][16:10]);
      reg_wr(vec_a(p), {10'd0, VEC[k][9:0], 12'd0});
      @(negedge clk); irq[p] = 1'b1;
      take_msg(VEC[k][9:0], "R10 R5 edge msg");
      quiet(8, "R5 held high");
      irq[p] = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R8 priority, R9 stall stability
    reg_wr(vec_a(5), {10'd0, 10'h055, 12'd0});
    reg_wr(vec_a(9), {10'd0, 10'h099, 12'd0});
    @(negedge clk); irq[9] = 1'b1; irq[5] = 1'b1;
    repeat (8) @(negedge clk);
    chk(valid && evt == 10'h055, "R8 lowest first", {22'd0, evt}, 32'h55);
    repeat (4) @(negedge clk);
    chk(valid && evt == 10'h055, "R9 stalled hold", {22'd0, evt}, 32'h55);
    ready = 1'b1; @(negedge clk); ready = 1'b0;
    chk(!valid, "R9 gap", {31'd0, valid}, 32'd0);
    take_msg(10'h099, "R8 second");
    irq[9] = 1'b0; irq[5] = 1'b0;

    // R6 / R7 level line on local pin 3 (global 67 -> 0xA008 bit 3)
    reg_wr(16'h1000, 32'h0000_0008);
    reg_wr(vec_a(3), {10'd0, 10'h1C3, 12'd0});
    @(negedge clk); irq[3] = 1'b1;
    take_msg(10'h1C3, "R6 level msg");
    quiet(10, "R6 locked");
    reg_rd(16'hA008, d); chk(d == 32'h8, "R7 status set", d, 32'h8);
    reg_wr(16'hA008, 32'h0);
    reg_rd(16'hA008, d); chk(d == 32'h8, "R7 zero write", d, 32'h8);
    reg_wr(16'hA000, 32'hFFFF_FFFF);
    reg_rd(16'hA008, d); chk(d == 32'h8, "R4 reserved clear", d, 32'h8);
    quiet(4, "R6 still locked");
    reg_wr(16'hA008, 32'h8);
    take_msg(10'h1C3, "R6 after clear");
    irq[3] = 1'b0;
    repeat (4) @(negedge clk);
    reg_wr(16'hA008, 32'h8);
    reg_rd(16'hA008, d); chk(d == 0, "R7 cleared", d, 0);
    quiet(8, "R6 low input");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule